// File: doc/BRIEF.md
# Serial Flash Command Engine

This block drives a single-lane SPI flash in clock mode 3 (clock idle high, data launched on the falling edge, sampled on the rising edge) from a small register file. Software first loads a 24-bit address register and a 32-bit data register. It then writes a command word. That write starts one transfer: an opcode byte, zero to three address bytes, zero to fifteen zero-valued dummy bytes, and zero to four data bytes, which are either sent from the data register or received into it.

A keep-select flag in the command word holds the chip select low after the command ends. The next command then continues the same flash frame without repeating its opcode, so software can build a long frame from several short commands. A status register shows a pending flag and a sticky error flag. A timing register sets the serial clock period and the positions of its two edges in core clock cycles. An idle-level register drives the write-protect and hold pins and the idle level of the output data line.

Top module: `sfc_cmd_engine`

## Requirements
- R1: A command word whose data count (bits 11:9) is greater than 4 sets the error flag (status bit 29), starts no transfer and produces no serial clock edge.
- R2: A command word written while the pending flag is set sets the error flag and is dropped. The transfer already in progress completes unchanged.
- R3: Command word layout: opcode 7:0, write flag 8, data count 11:9, keep-select 15, dummy count 19:16, address count 22:20, select index 26:24. Bytes go out MSB-first in this order: opcode, the address bytes starting from the most significant used byte of the address register, then the dummy bytes as 0x00.
- R4: In a write (bit 8 = 1), the data bytes follow the dummy bytes, taken from the data register in little-endian order (bits 7:0 first). The data register keeps its value.
- R5: In a read (bit 8 = 0), each received byte i is stored in data register bits 8i+7:8i, and the bytes above the count read back as zero. During read bytes the output line carries idle-level bit 0.
- R6: The pending flag (status bit 22) reads 1 from the cycle after an accepted command write until the transfer ends. The error flag is sticky and is cleared by writing 1 to bit 29 of the status register.
- R7: With keep-select set, the chip select stays low after the command. A command issued while it is held sends no opcode, only its address, dummy and data bytes, and uses the held select line.
- R8: A command with zero address, dummy and data counts and keep-select clear, issued while the select is held, produces no clock edge and releases the select.
- R9: The serial clock idles high. Timing register fields: period 3:0, rise position 11:8, fall position 15:12. Each bit lasts `period` core cycles with the clock low for `rise - fall` of them, and bytes follow each other with no gap.
- R10: Idle-level register bit 3 drives the hold pin, bit 2 the write-protect pin and bit 0 the idle level of the output data line. It resets to 4'b1100.
- R11: The address register is 24 bits wide. Bits 31:24 of a write are ignored and read back as zero.
- R12: The select index drives exactly one active-low select output. An index of NUM_CS or above asserts none, but the transfer still clocks.
- R13: After reset: status reads 0, all selects are high, the clock is high, and the timing register reads 0x0000_0102 (a divide-by-2 clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 command, 1 address, 2 data, 3 status, 4 timing, 5 idle levels |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| wp_n_o | output | 1 | Write-protect pin level |
| hold_n_o | output | 1 | Hold pin level |

## Verification
The bench builds the engine with NUM_CS = 2. This keeps both the selected-line case and the out-of-range-index case small enough to check directly. The main sweep runs every combination of direction, address count 0–3, dummy count 0–2 and data count 0–4. A flash model in the bench returns bytes computed from their position in the frame, so every frame and every read word is predicted exactly. A second sweep walks five period and edge settings and measures the clock low time and the bit period in core cycles.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int ADDR_BYTES = 3;
    localparam int DATA_BYTES = 4;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int DATA_W     = 8 * DATA_BYTES;

    localparam logic [2:0] REG_CMD  = 3'd0;
    localparam logic [2:0] REG_ADDR = 3'd1;
    localparam logic [2:0] REG_DATA = 3'd2;
    localparam logic [2:0] REG_STAT = 3'd3;
    localparam logic [2:0] REG_TIME = 3'd4;
    localparam logic [2:0] REG_IDLE = 3'd5;

    localparam int STAT_PEND_BIT = 22;
    localparam int STAT_ERR_BIT  = 29;

    typedef enum logic [2:0] {
        PH_OP   = 3'd0,
        PH_ADDR = 3'd1,
        PH_DUM  = 3'd2,
        PH_DATA = 3'd3,
        PH_END  = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FIN   = 2'd2
    } seq_st_t;

    typedef struct packed {
        logic [7:0] opcode;
        logic       wr;
        logic [2:0] dlen;
        logic       keep;
        logic [3:0] dum;
        logic [2:0] alen;
        logic [2:0] csi;
    } cmd_t;

    typedef struct packed {
        logic [3:0] per;
        logic [3:0] rise;
        logic [3:0] fall;
    } timing_t;
endpackage

// File: rtl/sfc_bitclk.sv
module sfc_bitclk
    import sfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  timing_t tcfg,
    output logic    sck_o,
    output logic    fall_stb,
    output logic    rise_stb,
    output logic    bit_end
);
    typedef struct packed {
        logic [3:0] ph;
        logic       sck;
    } clk_state_t;

    clk_state_t q, d;
    logic [3:0] per_eff;

    always_comb begin
        per_eff  = (tcfg.per < 4'd2) ? 4'd2 : tcfg.per;
        fall_stb = run && (q.ph == tcfg.fall);
        rise_stb = run && (q.ph == tcfg.rise);
        bit_end  = run && (q.ph == per_eff - 4'd1);
        d = q;
        if (!run) begin
            d.ph  = '0;
            d.sck = 1'b1;
        end else begin
            d.ph = bit_end ? 4'd0 : q.ph + 4'd1;
            if (fall_stb)      d.sck = 1'b0;
            else if (rise_stb) d.sck = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: 4'd0, sck: 1'b1};
        else        q <= d;
    end

    assign sck_o = q.sck;
endmodule

// File: rtl/sfc_shift.sv
module sfc_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       fall_stb,
    input  logic       rise_stb,
    input  logic       bit_end,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    typedef struct packed {
        logic [7:0] tx;
        logic [7:0] rx;
        logic [2:0] cnt;
        logic       mosi;
    } sh_state_t;

    sh_state_t q, d;

    always_comb begin
        byte_done = bit_end && (q.cnt == 3'd7);
        rx_byte   = rise_stb ? {q.rx[6:0], miso} : q.rx;
        d = q;
        if (fall_stb) d.mosi = q.tx[7];
        if (rise_stb) d.rx   = {q.rx[6:0], miso};
        if (bit_end) begin
            d.cnt = q.cnt + 3'd1;
            d.tx  = {q.tx[6:0], 1'b0};
        end
        if (load) begin
            d.tx  = load_byte;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mosi = q.mosi;
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              idle_bit,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    output logic              run,
    output logic              load,
    output logic [7:0]        tx_byte,
    output logic              busy,
    output logic              held,
    output logic [2:0]        csi,
    output logic              rd_we,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        seq_st_t           st;
        phase_t            ph;
        logic [3:0]        idx;
        cmd_t              cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] buf_r;
        logic              held;
        logic [2:0]        csi;
    } seq_state_t;

    seq_state_t q, d;

    function automatic logic [3:0] phase_len(phase_t p, cmd_t c);
        case (p)
            PH_OP:   return 4'd1;
            PH_ADDR: return {1'b0, c.alen};
            PH_DUM:  return c.dum;
            PH_DATA: return {1'b0, c.dlen};
            default: return 4'd0;
        endcase
    endfunction

    // first phase at or after p that carries at least one byte
    function automatic phase_t first_from(phase_t p, cmd_t c);
        phase_t found;
        found = PH_END;
        for (int k = 3; k >= 0; k--) begin
            if (k >= int'(p) && phase_len(phase_t'(k), c) != 4'd0)
                found = phase_t'(k);
        end
        return found;
    endfunction

    function automatic logic [7:0] byte_for(phase_t p, logic [3:0] i, cmd_t c,
                                            logic [ADDR_W-1:0] a,
                                            logic [DATA_W-1:0] b, logic idl);
        logic [ADDR_W-1:0] at;
        logic [DATA_W-1:0] bt;
        at = a >> (8 * (int'(c.alen) - 1 - int'(i)));
        bt = b >> (8 * int'(i));
        case (p)
            PH_OP:   return c.opcode;
            PH_ADDR: return at[7:0];
            PH_DATA: return c.wr ? bt[7:0] : {8{idl}};
            default: return 8'h00;
        endcase
    endfunction

    always_comb begin
        d     = q;
        load  = 1'b0;
        rd_we = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cmd   = cmd;
                    d.addr  = addr;
                    d.buf_r = cmd.wr ? wdata : '0;
                    d.csi   = q.held ? q.csi : cmd.csi;
                    d.held  = 1'b1;
                    d.idx   = '0;
                    d.ph    = first_from(q.held ? PH_ADDR : PH_OP, cmd);
                    if (d.ph == PH_END) begin
                        d.st = ST_FIN;
                    end else begin
                        d.st = ST_SHIFT;
                        load = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (byte_done) begin
                    if (q.ph == PH_DATA && !q.cmd.wr)
                        d.buf_r[{q.idx[1:0], 3'b000} +: 8] = rx_byte;
                    if (q.idx + 4'd1 < phase_len(q.ph, q.cmd)) begin
                        d.idx = q.idx + 4'd1;
                        load  = 1'b1;
                    end else begin
                        d.idx = '0;
                        d.ph  = first_from(phase_t'(q.ph + 3'd1), q.cmd);
                        if (d.ph == PH_END) d.st = ST_FIN;
                        else                load = 1'b1;
                    end
                end
            end
            default: begin
                if (!q.cmd.keep) d.held = 1'b0;
                rd_we = !q.cmd.wr && (q.cmd.dlen != 3'd0);
                d.st  = ST_IDLE;
            end
        endcase
        tx_byte = byte_for(d.ph, d.idx, d.cmd, d.addr, d.buf_r, idle_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, ph: PH_OP, default: '0};
        else        q <= d;
    end

    assign run     = (q.st == ST_SHIFT);
    assign busy    = (q.st != ST_IDLE);
    assign held    = q.held;
    assign csi     = q.csi;
    assign rd_data = q.buf_r;
endmodule

// File: rtl/sfc_cmd_engine.sv
module sfc_cmd_engine
    import sfc_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sck_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              wp_n_o,
    output logic              hold_n_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        timing_t           tcfg;
        logic [3:0]        idle;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;

    cmd_t              dcmd;
    logic              cmd_wr, cmd_bad, start;
    logic              seq_busy, seq_held, seq_run, seq_load, rd_we;
    logic [2:0]        seq_csi;
    logic [7:0]        tx_byte, rx_byte;
    logic [DATA_W-1:0] rd_data;
    logic              fall_stb, rise_stb, bit_end, byte_done, sh_mosi;
    logic              err_now;

    always_comb begin
        dcmd.opcode = reg_wdata[7:0];
        dcmd.wr     = reg_wdata[8];
        dcmd.dlen   = reg_wdata[11:9];
        dcmd.keep   = reg_wdata[15];
        dcmd.dum    = reg_wdata[19:16];
        dcmd.alen   = reg_wdata[22:20];
        dcmd.csi    = reg_wdata[26:24];
        cmd_wr  = reg_wr && (reg_addr == REG_CMD);
        cmd_bad = seq_busy || (dcmd.dlen > 3'(DATA_BYTES));
        start   = cmd_wr && !cmd_bad;

        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                REG_ADDR: r_d.addr = reg_wdata[ADDR_W-1:0];
                REG_DATA: r_d.data = reg_wdata[DATA_W-1:0];
                REG_STAT: if (reg_wdata[STAT_ERR_BIT]) r_d.err = 1'b0;
                REG_TIME: r_d.tcfg = '{per: reg_wdata[3:0], rise: reg_wdata[11:8],
                                       fall: reg_wdata[15:12]};
                REG_IDLE: r_d.idle = reg_wdata[3:0];
                default: ;
            endcase
        end
        if (cmd_wr && cmd_bad) r_d.err  = 1'b1;
        if (rd_we)             r_d.data = rd_data;

        reg_rdata = '0;
        case (reg_addr)
            REG_ADDR: reg_rdata[ADDR_W-1:0] = r_q.addr;
            REG_DATA: reg_rdata[DATA_W-1:0] = r_q.data;
            REG_STAT: begin
                reg_rdata[STAT_PEND_BIT] = seq_busy;
                reg_rdata[STAT_ERR_BIT]  = r_q.err;
            end
            REG_TIME: reg_rdata[15:0] = {r_q.tcfg.fall, r_q.tcfg.rise, 4'b0000, r_q.tcfg.per};
            REG_IDLE: reg_rdata[3:0] = r_q.idle;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.tcfg <= '{per: 4'd2, rise: 4'd1, fall: 4'd0};
            r_q.idle <= 4'b1100;
        end else begin
            r_q <= r_d;
        end
    end

    sfc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (dcmd),
        .addr     (r_q.addr),
        .wdata    (r_q.data),
        .idle_bit (r_q.idle[0]),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .run      (seq_run),
        .load     (seq_load),
        .tx_byte  (tx_byte),
        .busy     (seq_busy),
        .held     (seq_held),
        .csi      (seq_csi),
        .rd_we    (rd_we),
        .rd_data  (rd_data)
    );

    sfc_bitclk u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (seq_run),
        .tcfg    (r_q.tcfg),
        .sck_o   (sck_o),
        .fall_stb(fall_stb),
        .rise_stb(rise_stb),
        .bit_end (bit_end)
    );

    sfc_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .load_byte(tx_byte),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .bit_end  (bit_end),
        .miso     (miso_i),
        .mosi     (sh_mosi),
        .rx_byte  (rx_byte),
        .byte_done(byte_done)
    );

    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        assign cs_n_o[k] = !(seq_held && (seq_csi == 3'(k)));
    end

    assign mosi_o   = seq_busy ? sh_mosi : r_q.idle[0];
    assign wp_n_o   = r_q.idle[2];
    assign hold_n_o = r_q.idle[3];
    assign err_now  = r_q.err;
endmodule

// File: rtl/sfc_cmd_engine_chk.sv
module sfc_cmd_engine_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [2:0]        dlen_f,
    input logic              clr_f,
    input logic              busy,
    input logic              err,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_n
);
    assert_bad_len_error_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && !busy && dlen_f > 3'd4) |=> (err && !busy));

    assert_busy_cmd_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && busy) |=> err);

    assert_start_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && !busy && dlen_f <= 3'd4) |=> busy);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr && reg_addr == 3'd3 && clr_f)) |=> err);

    assert_sck_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);

    assert_one_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
endmodule

bind sfc_cmd_engine sfc_cmd_engine_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .dlen_f  (reg_wdata[11:9]),
    .clr_f   (reg_wdata[29]),
    .busy    (seq_busy),
    .err     (err_now),
    .sck     (sck_o),
    .cs_n    (cs_n_o)
);

// File: tb/sfc_cmd_engine_tb_top.sv
module sfc_cmd_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        sck_o, mosi_o, wp_n_o, hold_n_o;
    logic        miso_i = 1'b0;
    logic [1:0]  cs_n_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    sfc_cmd_engine #(.NUM_CS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o),
        .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .wp_n_o(wp_n_o), .hold_n_o(hold_n_o)
    );

    // ---------------- flash model ----------------
    logic       csn_all;
    logic [7:0] cap [0:63];
    int         cap_n = 0;
    int         rcnt = 0;
    int         sck_rises = 0;
    logic [7:0] shreg = 8'h00;
    assign csn_all = &cs_n_o;

    function automatic logic [7:0] resp(int k);
        return 8'((k * 29 + 60) & 255);
    endfunction

    always @(negedge csn_all) begin
        cap_n = 0;
        rcnt  = 0;
    end
    always @(posedge sck_o) begin
        sck_rises++;
        if (!csn_all) begin
            shreg = {shreg[6:0], mosi_o};
            rcnt++;
            if (rcnt % 8 == 0 && cap_n < 64) begin
                cap[cap_n] = shreg;
                cap_n++;
            end
        end
    end
    always @(negedge sck_o) begin
        logic [7:0] rb;
        if (!csn_all) begin
            rb = resp(rcnt / 8);
            miso_i = rb[7 - (rcnt % 8)];
        end
    end

    // ---------------- clock shape monitor ----------------
    int   lowrun = 0, lo_min = 999, lo_max = 0, per_min = 999, per_max = 0, last_rise = -1;
    logic prev_sck = 1'b1;
    always @(negedge clk) begin
        if (!sck_o) lowrun++;
        else begin
            if (!prev_sck) begin
                if (lowrun < lo_min) lo_min = lowrun;
                if (lowrun > lo_max) lo_max = lowrun;
                if (last_rise >= 0) begin
                    if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                    if (cyc - last_rise > per_max) per_max = cyc - last_rise;
                end
                last_rise = cyc;
            end
            lowrun = 0;
        end
        prev_sck = sck_o;
    end

    task automatic mon_clear();
        lo_min = 999; lo_max = 0; per_min = 999; per_max = 0; last_rise = -1;
    endtask

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(3'd3, s);
            if (!s[22]) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] mk_cmd(logic [7:0] op, logic wr, logic [2:0] dlen,
                                           logic keep, logic [3:0] dum, logic [2:0] alen,
                                           logic [2:0] csi);
        return {5'b0, csi, 1'b0, alen, dum, keep, 3'b000, dlen, wr, op};
    endfunction

    // watchdog
    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, a, wd, expd;
        logic [7:0]  ex [0:31];
        int          en, k0, r0;
        bit          ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        rd_reg(3'd3, v);
        chk(v == 32'd0, "R13", "status after reset", v, 32'd0);
        rd_reg(3'd4, v);
        chk(v == 32'h0000_0102, "R13", "timing after reset", v, 32'h0000_0102);
        chk(cs_n_o == 2'b11 && sck_o == 1'b1, "R13", "pins after reset",
            {30'd0, cs_n_o}, 32'd3);
        chk(hold_n_o && wp_n_o && !mosi_o, "R10", "idle pins after reset",
            {29'd0, hold_n_o, wp_n_o, mosi_o}, 32'd6);

        // R11 address register width
        wr_reg(3'd1, 32'hFF12_3456);
        rd_reg(3'd1, v);
        chk(v == 32'h0012_3456, "R11", "address readback", v, 32'h0012_3456);

        // Main sweep: R3 R4 R5
        for (int wr = 0; wr < 2; wr++)
            for (int al = 0; al < 4; al++)
                for (int dm = 0; dm < 3; dm++)
                    for (int dl = 0; dl < 5; dl++) begin
                        int it;
                        it = ((wr * 4 + al) * 3 + dm) * 5 + dl;
                        a  = (32'h00A1_B2C3 ^ (32'(it) * 32'h0001_0203)) & 32'h00FF_FFFF;
                        wd = 32'h1122_3344 + 32'(it) * 32'h0101_0101;
                        wr_reg(3'd1, a);
                        wr_reg(3'd2, wd);
                        wr_reg(3'd0, mk_cmd(8'(8'h40 + it), wr[0], 3'(dl), 1'b0,
                                            4'(dm), 3'(al), 3'd0));
                        rd_reg(3'd3, v);
                        if (it == 0)
                            chk(v[22] == 1'b1, "R6", "pending after command", v, 32'h0040_0000);
                        wait_done();
                        en = 0;
                        ex[en++] = 8'(8'h40 + it);
                        for (int j = 0; j < al; j++) ex[en++] = a[8 * (al - 1 - j) +: 8];
                        for (int j = 0; j < dm; j++) ex[en++] = 8'h00;
                        for (int j = 0; j < dl; j++) ex[en++] = (wr != 0) ? wd[8 * j +: 8] : 8'h00;
                        ok = (cap_n == en) && csn_all;
                        for (int j = 0; j < en; j++) if (ok && cap[j] != ex[j]) ok = 0;
                        chk(ok, (wr != 0) ? "R4" : "R3", "frame bytes/count",
                            32'(cap_n), 32'(en));
                        rd_reg(3'd2, v);
                        if (wr != 0) begin
                            chk(v == wd, "R4", "data kept after write", v, wd);
                        end else if (dl > 0) begin
                            expd = 32'd0;
                            k0 = 1 + al + dm;
                            for (int j = 0; j < dl; j++) expd[8 * j +: 8] = resp(k0 + j);
                            chk(v == expd, "R5", "read data packing", v, expd);
                        end
                    end

        // R9 clock timing sweep
        for (int t = 0; t < 5; t++) begin
            int p, r, f;
            p = (t == 0) ? 2 : (t == 1) ? 4 : (t == 2) ? 6 : (t == 3) ? 8 : 15;
            r = (t == 0) ? 1 : (t == 1) ? 2 : (t == 2) ? 3 : (t == 3) ? 6 : 9;
            f = (t == 0) ? 0 : (t == 1) ? 0 : (t == 2) ? 1 : (t == 3) ? 2 : 3;
            wr_reg(3'd4, {16'd0, 4'(f), 4'(r), 4'd0, 4'(p)});
            mon_clear();
            wr_reg(3'd1, 32'h0000_5A00);
            wr_reg(3'd0, mk_cmd(8'h9F, 1'b0, 3'd0, 1'b0, 4'd0, 3'd2, 3'd0));
            wait_done();
            chk(lo_min == r - f && lo_max == r - f, "R9", "clock low time",
                32'(lo_max), 32'(r - f));
            chk(per_min == p && per_max == p, "R9", "bit period", 32'(per_max), 32'(p));
            chk(cap_n == 3 && cap[0] == 8'h9F && cap[1] == 8'h5A && cap[2] == 8'h00,
                "R9", "bytes at this timing", {cap[0], cap[1], cap[2], 8'(cap_n)},
                32'h9F5A_0003);
        end
        wr_reg(3'd4, 32'h0000_0102);

        // R7 continuation
        wr_reg(3'd1, 32'h0012_3456);
        wr_reg(3'd0, mk_cmd(8'h0B, 1'b0, 3'd0, 1'b1, 4'd1, 3'd3, 3'd0));
        wait_done();
        chk(cs_n_o == 2'b10, "R7", "select held after keep", {30'd0, cs_n_o}, 32'd2);
        wr_reg(3'd0, mk_cmd(8'hEE, 1'b0, 3'd4, 1'b0, 4'd0, 3'd0, 3'd1));
        wait_done();
        ok = (cap_n == 9) && cap[0] == 8'h0B && cap[1] == 8'h12 && cap[2] == 8'h34 &&
             cap[3] == 8'h56 && cap[4] == 8'h00;
        chk(ok && csn_all, "R7", "continued frame", 32'(cap_n), 32'd9);
        rd_reg(3'd2, v);
        expd = {resp(8), resp(7), resp(6), resp(5)};
        chk(v == expd, "R7", "continued read data", v, expd);

        // R8 release only
        wr_reg(3'd0, mk_cmd(8'h05, 1'b1, 3'd0, 1'b1, 4'd0, 3'd0, 3'd0));
        wait_done();
        r0 = sck_rises;
        wr_reg(3'd0, mk_cmd(8'h00, 1'b0, 3'd0, 1'b0, 4'd0, 3'd0, 3'd0));
        wait_done();
        repeat (4) @(negedge clk);
        chk(sck_rises == r0 && csn_all && cap_n == 1, "R8", "release only",
            32'(sck_rises - r0), 32'd0);

        // R1 bad data count
        r0 = sck_rises;
        wr_reg(3'd0, mk_cmd(8'h03, 1'b0, 3'd5, 1'b0, 4'd0, 3'd0, 3'd0));
        rd_reg(3'd3, v);
        chk(v == 32'h2000_0000, "R1", "status after bad count", v, 32'h2000_0000);
        repeat (40) @(negedge clk);
        chk(sck_rises == r0 && csn_all, "R1", "no transfer on bad count",
            32'(sck_rises - r0), 32'd0);

        // R6 error clear
        wr_reg(3'd3, 32'h2000_0000);
        rd_reg(3'd3, v);
        chk(v == 32'd0, "R6", "error cleared by write one", v, 32'd0);

        // R2 command while pending
        wr_reg(3'd1, 32'h00AB_CDEF);
        wr_reg(3'd2, 32'hDEAD_BEEF);
        wr_reg(3'd0, mk_cmd(8'h02, 1'b1, 3'd4, 1'b0, 4'd2, 3'd3, 3'd0));
        wr_reg(3'd0, mk_cmd(8'h77, 1'b1, 3'd1, 1'b0, 4'd0, 3'd0, 3'd0));
        wait_done();
        ok = cap_n == 10 && cap[0] == 8'h02 && cap[1] == 8'hAB && cap[3] == 8'hEF &&
             cap[4] == 8'h00 && cap[6] == 8'hEF && cap[9] == 8'hDE;
        chk(ok, "R2", "first transfer intact", 32'(cap_n), 32'd10);
        rd_reg(3'd3, v);
        chk(v == 32'h2000_0000, "R2", "error after busy write", v, 32'h2000_0000);
        wr_reg(3'd3, 32'h2000_0000);

        // R12 select index
        wr_reg(3'd0, mk_cmd(8'h9F, 1'b0, 3'd2, 1'b0, 4'd0, 3'd0, 3'd1));
        repeat (3) @(negedge clk);
        chk(cs_n_o == 2'b01, "R12", "index 1 selects line 1", {30'd0, cs_n_o}, 32'd1);
        wait_done();
        r0 = sck_rises;
        wr_reg(3'd0, mk_cmd(8'h9F, 1'b0, 3'd0, 1'b0, 4'd0, 3'd0, 3'd5));
        repeat (4) @(negedge clk);
        chk(cs_n_o == 2'b11, "R12", "out of range index", {30'd0, cs_n_o}, 32'd3);
        wait_done();
        chk(sck_rises - r0 == 8, "R12", "clock still runs", 32'(sck_rises - r0), 32'd8);

        // R10 idle levels
        wr_reg(3'd5, 32'h0000_0001);
        chk(!hold_n_o && !wp_n_o && mosi_o, "R10", "idle levels low pins",
            {29'd0, hold_n_o, wp_n_o, mosi_o}, 32'd1);
        wr_reg(3'd5, 32'h0000_000D);
        wr_reg(3'd0, mk_cmd(8'h03, 1'b0, 3'd1, 1'b0, 4'd0, 3'd0, 3'd0));
        wait_done();
        chk(cap_n == 2 && cap[1] == 8'hFF && hold_n_o && wp_n_o, "R10",
            "read fill from idle bit", {24'd0, cap[1]}, 32'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule